// File: doc/BRIEF.md
# Exception Base Register and Handler Vector Unit

This block holds the 32-bit exception base of a system control coprocessor and works out where execution goes when an exception is taken. Software writes the base through a data-plus-enable port and reads it back directly. A write-gate bit at position 11 of the written word, honoured only when the gate feature is switched on, decides whether the two top address bits may change in that write. The decision is made from the incoming word alone, never from the stored copy. Bits 10:0 are never written and keep their reset value.

When an exception request arrives, the block registers three results on that clock edge: the handler address, the saved resume PC, and the 5-bit exception code for the Cause register. The handler address uses one of three bases. The first is a fixed boot base when the boot-vector select is high. The second is an uncached alias window for cache errors, unless the keep-cached control is high. The third is the stored base with its low 12 bits cleared. An offset is then added: 0x100 for cache errors and 0x180 for all other exceptions.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, rd_data is 0x80000000 and handler_pc, epc and cause_code are all zero.
- R2: A write with gate_support=1 and wr_data[11]=1 loads bits 31:11 from wr_data and leaves bits 10:0 unchanged.
- R3: Any other write loads only bits 29:11 from wr_data; bits 31:30 and 10:0 keep their previous values.
- R4: The gate decision uses wr_data[11] only. A stored bit 11 of 1 does not open the gate for a write whose bit 11 is 0.
- R5: On a request with boot_vec_sel=1, handler_pc = 0xBFC00200 + 0x100 for a cache error, or + 0x180 otherwise.
- R6: On a cache-error request with boot_vec_sel=0 and keep_cached=0, handler_pc = (0xA0000000 | (base & 0x1FFFF000)) + 0x100.
- R7: On any other request with boot_vec_sel=0, handler_pc = (base & 0xFFFFF000) + offset, where the offset is 0x100 for a cache error and 0x180 otherwise.
- R8: On a request, epc loads fault_pc when exc_level=0 and holds its value when exc_level=1.
- R9: On a request, cause_code (Cause bits 6:2) becomes 30 when cache_err=1, and exc_code otherwise.
- R10: A base write in the same cycle as a request does not affect that request's handler_pc. It does affect later requests.
- R11: Without a request, handler_pc, epc and cause_code hold their values. Without wr_en, rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Base register write enable |
| wr_data | input | 32 | Base register write value; bit 11 is the gate |
| gate_support | input | 1 | Enables the write-gate feature |
| rd_data | output | 32 | Current base register value |
| boot_vec_sel | input | 1 | Selects the fixed boot vector base |
| keep_cached | input | 1 | Suppresses the uncached alias for cache errors |
| exc_level | input | 1 | Exception already active; blocks the EPC update |
| exc_req | input | 1 | Exception taken this cycle |
| exc_code | input | 5 | Cause code for exceptions that are not cache errors |
| cache_err | input | 1 | Exception is a cache error |
| fault_pc | input | 32 | Resume PC of the faulting instruction |
| handler_pc | output | 32 | Registered handler address |
| epc | output | 32 | Registered resume PC |
| cause_code | output | 5 | Registered Cause exception-code field |

## Verification
The bench writes values where bit 11 is set in the stored base but clear in the new word. A design that read the gate from stored state would let bits 31:30 change on such writes. It also writes with the gate bit set while gate support is off, where the top bits must stay put. It issues cache errors under each combination of boot-vector select and keep-cached. A design that missed the alias window or used the wrong offset would return 0x...180 or a base above 0xBFFFFFFF where the window is required. It also raises a request in the same cycle as a base write. A design that forwarded the new value would show the new base in that request's handler address. Finally it repeats requests with exc_level set, where a careless design would overwrite epc.

// File: rtl/evu_pkg.sv
package evu_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Mask of bits below position n
  function automatic word_t low_mask(int n);
    return (word_t'(1) << n) - word_t'(1);
  endfunction

  // New register value after a write; keep-mask chosen by the gate
  function automatic word_t gated_merge(word_t cur, word_t wv, logic gate_open,
                                        int gate_bit, int prot_hi);
    word_t keep;
    word_t top_keep;
    top_keep = ~(word_t'('1) >> prot_hi);
    keep     = gate_open ? low_mask(gate_bit) : (low_mask(gate_bit) | top_keep);
    return (cur & keep) | (wv & ~keep);
  endfunction

  // Base with the page-offset bits cleared
  function automatic word_t page_base(word_t b, int page_bits);
    return b & ~low_mask(page_bits);
  endfunction

  // Page bits of the base placed inside a fixed uncached window
  function automatic word_t alias_base(word_t b, word_t win, int page_bits, int win_bits);
    return win | (b & low_mask(win_bits) & ~low_mask(page_bits));
  endfunction
endpackage

// File: rtl/evu_base_reg.sv
module evu_base_reg
  import evu_pkg::*;
#(
  parameter int    GATE_BIT   = 11,
  parameter int    PROT_HI    = 2,
  parameter word_t RESET_BASE = 32'h8000_0000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wr_data,
  input  logic  gate_support,
  output word_t base_q,
  output logic  gate_open
);
  // Gate comes from the incoming word only
  assign gate_open = gate_support & wr_data[GATE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= RESET_BASE;
    end else if (wr_en) begin
      base_q <= gated_merge(base_q, wr_data, gate_open, GATE_BIT, PROT_HI);
    end
  end
endmodule

// File: rtl/evu_vector_calc.sv
module evu_vector_calc
  import evu_pkg::*;
#(
  parameter int    PAGE_BITS  = 12,
  parameter int    WIN_BITS   = 29,
  parameter word_t BOOT_BASE  = 32'hBFC0_0000,
  parameter word_t BOOT_EXTRA = 32'h0000_0200,
  parameter word_t UNC_WIN    = 32'hA000_0000,
  parameter word_t GEN_OFS    = 32'h0000_0180,
  parameter word_t CERR_OFS   = 32'h0000_0100
) (
  input  word_t base,
  input  logic  boot_sel,
  input  logic  keep_cached,
  input  logic  cache_err,
  output word_t target,
  output logic  take_uncached
);
  localparam word_t BOOT_VEC = BOOT_BASE + BOOT_EXTRA;

  word_t sel_base;
  word_t ofs;

  assign take_uncached = cache_err & ~keep_cached & ~boot_sel;
  assign ofs           = cache_err ? CERR_OFS : GEN_OFS;

  always_comb begin
    if (boot_sel)           sel_base = BOOT_VEC;
    else if (take_uncached) sel_base = alias_base(base, UNC_WIN, PAGE_BITS, WIN_BITS);
    else                    sel_base = page_base(base, PAGE_BITS);
  end

  assign target = sel_base + ofs;
endmodule

// File: rtl/evu_exc_latch.sv
module evu_exc_latch
  import evu_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int CERR_CODE = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              exl,
  input  logic              cache_err,
  input  logic [CODE_W-1:0] code_in,
  input  word_t             target,
  input  word_t             fault_pc,
  output word_t             handler_pc,
  output word_t             epc,
  output logic [CODE_W-1:0] code_out,
  output logic              epc_load
);
  localparam logic [CODE_W-1:0] CERR_VAL = CODE_W'(CERR_CODE);

  assign epc_load = req & ~exl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      handler_pc <= '0;
      epc        <= '0;
      code_out   <= '0;
    end else begin
      if (req) begin
        handler_pc <= target;
        code_out   <= cache_err ? CERR_VAL : code_in;
      end
      if (epc_load) epc <= fault_pc;
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import evu_pkg::*;
#(
  parameter int    CODE_W     = 5,
  parameter int    GATE_BIT   = 11,
  parameter int    PROT_HI    = 2,
  parameter int    PAGE_BITS  = 12,
  parameter int    WIN_BITS   = 29,
  parameter int    CERR_CODE  = 30,
  parameter word_t RESET_BASE = 32'h8000_0000,
  parameter word_t BOOT_BASE  = 32'hBFC0_0000,
  parameter word_t BOOT_EXTRA = 32'h0000_0200,
  parameter word_t UNC_WIN    = 32'hA000_0000,
  parameter word_t GEN_OFS    = 32'h0000_0180,
  parameter word_t CERR_OFS   = 32'h0000_0100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                gate_support,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                boot_vec_sel,
  input  logic                keep_cached,
  input  logic                exc_level,
  input  logic                exc_req,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic                cache_err,
  input  logic [WORD_W-1:0]   fault_pc,
  output logic [WORD_W-1:0]   handler_pc,
  output logic [WORD_W-1:0]   epc,
  output logic [CODE_W-1:0]   cause_code
);
  // Named internal events, visible to the checker
  word_t base_w;
  word_t target_w;
  logic  gate_open_w;
  logic  take_uncached_w;
  logic  epc_load_w;

  evu_base_reg #(
    .GATE_BIT(GATE_BIT), .PROT_HI(PROT_HI), .RESET_BASE(RESET_BASE)
  ) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .gate_support(gate_support), .base_q(base_w), .gate_open(gate_open_w)
  );

  evu_vector_calc #(
    .PAGE_BITS(PAGE_BITS), .WIN_BITS(WIN_BITS), .BOOT_BASE(BOOT_BASE),
    .BOOT_EXTRA(BOOT_EXTRA), .UNC_WIN(UNC_WIN), .GEN_OFS(GEN_OFS), .CERR_OFS(CERR_OFS)
  ) u_vec (
    .base(base_w), .boot_sel(boot_vec_sel), .keep_cached(keep_cached),
    .cache_err(cache_err), .target(target_w), .take_uncached(take_uncached_w)
  );

  evu_exc_latch #(
    .CODE_W(CODE_W), .CERR_CODE(CERR_CODE)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .req(exc_req), .exl(exc_level), .cache_err(cache_err),
    .code_in(exc_code), .target(target_w), .fault_pc(fault_pc),
    .handler_pc(handler_pc), .epc(epc), .code_out(cause_code), .epc_load(epc_load_w)
  );

  assign rd_data = base_w;
endmodule

// File: rtl/evu_chk.sv
module evu_chk
  import evu_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int GATE_BIT  = 11,
  parameter int PROT_HI   = 2,
  parameter int CERR_CODE = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input word_t             wr_data,
  input word_t             rd_data,
  input logic              boot_vec_sel,
  input logic              exc_level,
  input logic              exc_req,
  input logic              cache_err,
  input word_t             fault_pc,
  input word_t             handler_pc,
  input word_t             epc,
  input logic [CODE_W-1:0] cause_code,
  input logic              gate_open_w,
  input logic              take_uncached_w,
  input logic              epc_load_w
);
  localparam int FREE_HI = WORD_W - PROT_HI - 1;

  // R2
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && gate_open_w |=> rd_data[WORD_W-1:GATE_BIT] == $past(wr_data[WORD_W-1:GATE_BIT])
                          && rd_data[GATE_BIT-1:0] == $past(rd_data[GATE_BIT-1:0]))
    else $error("gated write");

  // R3
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !gate_open_w |=> rd_data[WORD_W-1:FREE_HI+1] == $past(rd_data[WORD_W-1:FREE_HI+1])
                           && rd_data[FREE_HI:GATE_BIT] == $past(wr_data[FREE_HI:GATE_BIT])
                           && rd_data[GATE_BIT-1:0] == $past(rd_data[GATE_BIT-1:0]))
    else $error("plain write");

  // R4
  gate_from_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[GATE_BIT] |=> rd_data[WORD_W-1:FREE_HI+1] == $past(rd_data[WORD_W-1:FREE_HI+1]))
    else $error("gate taken from stored bit");

  // R5
  boot_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && boot_vec_sel |=> handler_pc[31:12] == 20'hBFC00)
    else $error("boot vector");

  // R6
  uncached_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && take_uncached_w |=> handler_pc[31:29] == 3'b101 && handler_pc[11:0] == 12'h100)
    else $error("uncached alias");

  // R8
  epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epc_load_w |=> epc == $past(fault_pc))
    else $error("epc load");

  // R8
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && exc_level |=> $stable(epc))
    else $error("epc hold under exl");

  // R9
  cerr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && cache_err |=> cause_code == CODE_W'(CERR_CODE))
    else $error("cache error code");

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |=> $stable(handler_pc) && $stable(cause_code) && $stable(epc))
    else $error("outputs moved without request");

  // R11
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data))
    else $error("base moved without write");
endmodule

bind exc_vector_unit evu_chk #(
  .CODE_W(CODE_W), .GATE_BIT(GATE_BIT), .PROT_HI(PROT_HI), .CERR_CODE(CERR_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .boot_vec_sel(boot_vec_sel), .exc_level(exc_level), .exc_req(exc_req),
  .cache_err(cache_err), .fault_pc(fault_pc), .handler_pc(handler_pc), .epc(epc),
  .cause_code(cause_code), .gate_open_w(gate_open_w),
  .take_uncached_w(take_uncached_w), .epc_load_w(epc_load_w)
);

// File: tb/exc_vector_unit_bench.sv
`timescale 1ns/1ps
module exc_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, gate_support, boot_vec_sel, keep_cached, exc_level, exc_req, cache_err;
  logic [31:0] wr_data, fault_pc, rd_data, handler_pc, epc;
  logic [4:0]  exc_code, cause_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_base, e_hpc, e_epc;
  logic [4:0]  e_code;

  always #5 clk = ~clk;

  exc_vector_unit u_exc_vector_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .gate_support(gate_support), .rd_data(rd_data), .boot_vec_sel(boot_vec_sel),
    .keep_cached(keep_cached), .exc_level(exc_level), .exc_req(exc_req),
    .exc_code(exc_code), .cache_err(cache_err), .fault_pc(fault_pc),
    .handler_pc(handler_pc), .epc(epc), .cause_code(cause_code)
  );

  // Bench model of the write rule, bit by bit
  function automatic logic [31:0] exp_write(logic [31:0] old, logic [31:0] wv, logic gs);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (i < 11)              r[i] = old[i];
      else if (i >= 30)        r[i] = (gs && wv[11]) ? wv[i] : old[i];
      else                     r[i] = wv[i];
    end
    return r;
  endfunction

  // Bench model of the handler address
  function automatic logic [31:0] exp_vec(logic [31:0] b, logic bev, logic cv, logic ce);
    logic [31:0] off;
    off = ce ? 32'h100 : 32'h180;
    case ({bev, ce && !cv})
      2'b10, 2'b11: return 32'hBFC0_0200 + off;
      2'b01:        return {3'b101, b[28:12], 12'h000} + off;
      default:      return {b[31:12], 12'h000} + off;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: drive at a falling edge, check at the next falling edge
  task automatic cyc(input logic we, input logic [31:0] wd, input logic gs,
                     input logic bev, input logic cv, input logic exl, input logic req,
                     input logic ce, input logic [4:0] code, input logic [31:0] pc);
    string rtag, htag;
    wr_en = we; wr_data = wd; gate_support = gs; boot_vec_sel = bev; keep_cached = cv;
    exc_level = exl; exc_req = req; cache_err = ce; exc_code = code; fault_pc = pc;
    if (!we)                rtag = "R11";
    else if (gs && wd[11])  rtag = "R2";
    else if (m_base[11])    rtag = "R4";
    else                    rtag = "R3";
    if (!req)               htag = "R11";
    else if (bev)           htag = "R5";
    else if (ce && !cv)     htag = "R6";
    else                    htag = "R7";
    if (req) begin
      e_hpc  = exp_vec(m_base, bev, cv, ce);
      e_code = ce ? 5'd30 : code;
      if (!exl) e_epc = pc;
    end
    if (we) m_base = exp_write(m_base, wd, gs);
    @(negedge clk);
    chk(rtag, rd_data, m_base);
    chk(htag, handler_pc, e_hpc);
    chk(req ? "R8" : "R11", epc, e_epc);
    chk(req ? "R9" : "R11", {27'd0, cause_code}, {27'd0, e_code});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5EED_0BA5);
    rst_n = 1'b0; wr_en = 0; wr_data = '0; gate_support = 0; boot_vec_sel = 0;
    keep_cached = 0; exc_level = 0; exc_req = 0; cache_err = 0; exc_code = '0; fault_pc = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", rd_data, 32'h8000_0000);
    chk("R1", handler_pc, 32'h0);
    chk("R1", epc, 32'h0);
    chk("R1", {27'd0, cause_code}, 32'h0);
    m_base = 32'h8000_0000; e_hpc = '0; e_epc = '0; e_code = '0;
    rst_n = 1'b1;

    // Directed corner cases
    cyc(1, 32'hFFFF_FFFF, 1, 0,0,0,0,0, 5'd0, 32'h0);          // R2: -> FFFFF800
    chk("R2", rd_data, 32'hFFFF_F800);
    cyc(1, 32'h1234_5000, 1, 0,0,0,0,0, 5'd0, 32'h0);          // R4: stored gate set, value clear
    chk("R4", rd_data, 32'hD234_5000);
    cyc(1, 32'h4000_0800, 0, 0,0,0,0,0, 5'd0, 32'h0);          // R3: gate bit but feature off
    chk("R3", rd_data, 32'hC000_0800);
    cyc(1, 32'h2ABC_D800, 1, 0,0,0,0,0, 5'd0, 32'h0);          // R2: base -> 2ABCD800
    cyc(0, 32'h0, 0, 1,0,0,1,0, 5'd8, 32'h0000_1000);          // R5 general
    chk("R5", handler_pc, 32'hBFC0_0380);
    cyc(0, 32'h0, 0, 1,0,0,1,1, 5'd3, 32'h0000_1004);          // R5 cache error
    chk("R5", handler_pc, 32'hBFC0_0300);
    chk("R9", {27'd0, cause_code}, 32'd30);
    cyc(0, 32'h0, 0, 0,0,0,1,1, 5'd3, 32'h0000_1008);          // R6
    chk("R6", handler_pc, 32'hAABC_D100);
    cyc(0, 32'h0, 0, 0,1,0,1,1, 5'd3, 32'h0000_100C);          // R7 cache error kept cached
    chk("R7", handler_pc, 32'h2ABC_D100);
    cyc(0, 32'h0, 0, 0,0,1,1,0, 5'd12, 32'h0000_2000);         // R8 hold under exl
    chk("R8", epc, 32'h0000_100C);
    chk("R9", {27'd0, cause_code}, 32'd12);
    cyc(1, 32'h0000_5000, 1, 0,0,0,1,0, 5'd4, 32'h0000_3000);  // R10 same cycle write
    chk("R10", handler_pc, 32'h2ABC_D180);
    cyc(0, 32'h0, 0, 0,0,0,1,0, 5'd4, 32'h0000_3004);          // R10 later request sees it
    chk("R10", handler_pc, 32'h0000_5180);
    cyc(0, 32'h0, 0, 0,0,0,0,0, 5'd7, 32'h0000_9999);          // R11 idle
    chk("R11", epc, 32'h0000_3004);

    // Constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rw, rpc;
      rw  = $urandom;
      rpc = $urandom;
      cyc(($urandom % 3) == 0, rw, ($urandom % 4) != 0,
          ($urandom % 5) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
          ($urandom % 2) == 0, ($urandom % 4) == 0, 5'($urandom), rpc);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule